// File: doc/BRIEF.md
# I2C Byte Shifter with Acknowledge

This block is the serial data path of an I2C controller. It keeps one byte of data and one hidden acknowledge flag, and together they work as a nine-position shift chain: eight data bits and then the acknowledge bit. The byte-level control logic around it decides when a transfer begins, whether the controller is sending or receiving, and which acknowledge level to return. It also supplies strobes marking the rising and falling edges of SCL and the SDA level sampled from the bus.

Bits arrive on rising SCL edges and leave on falling SCL edges, most significant bit first. A logic 1 stands for a high bus level. The byte register captures the bus level on every data rising edge, including while it is transmitting. When arbitration is lost partway through a byte, the register therefore already holds the byte that was actually on the bus. The CPU reads and writes the byte through a 32-bit register word. A write is accepted only while no byte is in flight. The block tells the control logic when the eighth data bit and the acknowledge bit have been taken.

Top module: `i2cs_byte_shifter`

## Requirements
- R1: After reset the byte register reads 0x00, `sda_o` is 1 (released), `busy_o` is 0, and `byte_done_o`, `ack_done_o` and `ack_bit_o` are 0.
- R2: `reg_rdata_o[31:8]` always reads zero. A write while idle loads `reg_wdata_i[7:0]` into the byte register, and the upper write bits have no effect.
- R3: While busy, each of the first eight rising-edge strobes shifts the byte register left by one and places the sampled `sda_i` in bit 0. After eight edges, the first bit received sits in bit 7.
- R4: The ninth rising-edge strobe stores `sda_i` in the acknowledge flag, shown on `ack_bit_o`, and leaves the byte register unchanged.
- R5: With `tx_mode_i` = 1, accepting `start_i` puts bit 7 of the register on `sda_o`. The falling-edge strobe after each of the first seven rising edges puts the next lower bit of the original byte on `sda_o`.
- R6: While transmitting, the register still captures the bus level. If the bus disagrees with the sent bit and `tx_mode_i` is then dropped, the register ends the byte holding the bus byte.
- R7: On the falling-edge strobe after the eighth rising edge, `sda_o` becomes 1 when `tx_mode_i` = 1, and becomes `ack_drive_i` when `tx_mode_i` = 0.
- R8: With `tx_mode_i` = 0, `sda_o` stays 1 during all eight data slots.
- R9: `start_i` while idle raises `busy_o` in the next cycle. `busy_o` falls together with the ninth rising edge. `start_i` while busy is ignored and does not restart the bit count.
- R10: A register write while busy, or in the same cycle as `start_i`, is ignored.
- R11: `byte_done_o` pulses for one cycle right after the eighth rising-edge strobe, and `ack_done_o` pulses for one cycle right after the ninth. The two pulses never coincide.
- R12: While idle, edge strobes leave the register unchanged, produce no pulse, and a falling-edge strobe leaves `sda_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | CPU write strobe for the data word |
| reg_wdata_i | input | 32 | CPU write data |
| reg_rdata_o | output | 32 | Data word: byte register in bits 7:0, zero above |
| start_i | input | 1 | Begin shifting one byte plus acknowledge |
| tx_mode_i | input | 1 | 1: drive the data bits; 0: release during data bits |
| ack_drive_i | input | 1 | Level to drive in the acknowledge slot when receiving |
| scl_rise_i | input | 1 | One-cycle strobe for a rising SCL edge |
| scl_fall_i | input | 1 | One-cycle strobe for a falling SCL edge |
| sda_i | input | 1 | Sampled SDA level |
| sda_o | output | 1 | SDA level to drive (1 = release/high) |
| busy_o | output | 1 | A byte is being shifted |
| byte_done_o | output | 1 | One-cycle pulse after the eighth data bit |
| ack_done_o | output | 1 | One-cycle pulse after the acknowledge bit |
| ack_bit_o | output | 1 | Last acknowledge level captured |

## Verification
The hardest case to reach is lost arbitration. The block must switch from transmitting to releasing the line in the middle of a byte, and still end with the bus byte, not the byte it began sending. The bench drives a bus byte that differs from the transmitted one at an inner bit. At the first mismatch it drops `tx_mode_i` between that rising strobe and the next falling strobe. It then checks `sda_o` in every remaining slot and checks the final register contents. Writes and starts that land in the middle of a byte, and a write in the same cycle as a start, are injected at fixed bit positions. This checks that the bit count and the register are untouched.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_ACK  = 2'd2
  } slot_e;
endpackage

// File: rtl/i2cs_bit_ctr.sv
module i2cs_bit_ctr
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  scl_rise_i,
  output logic  busy_o,
  output slot_e slot_o,
  output logic  cnt_zero_o,
  output logic  shift_data_o,
  output logic  shift_ack_o,
  output logic  byte_done_o,
  output logic  ack_done_o
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_POS   = CNT_W'(DATA_W);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_comb begin
    if (!busy_q)             slot_o = SLOT_IDLE;
    else if (cnt_q == ACK_POS) slot_o = SLOT_ACK;
    else                     slot_o = SLOT_DATA;
  end

  assign cnt_zero_o   = (cnt_q == '0);
  assign shift_data_o = scl_rise_i && (slot_o == SLOT_DATA);
  assign shift_ack_o  = scl_rise_i && (slot_o == SLOT_ACK);
  assign busy_o       = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      busy_q      <= 1'b0;
      byte_done_o <= 1'b0;
      ack_done_o  <= 1'b0;
    end else begin
      byte_done_o <= 1'b0;
      ack_done_o  <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (shift_data_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_DATA) byte_done_o <= 1'b1;
      end else if (shift_ack_o) begin
        cnt_q      <= '0;
        busy_q     <= 1'b0;
        ack_done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_shift_chain.sv
module i2cs_shift_chain #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              shift_data_i,
  input  logic              shift_ack_i,
  input  logic              sda_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ack_flag_o
);
  // data bits then ack flag form one chain; bus level always enters at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o     <= '0;
      ack_flag_o <= 1'b0;
    end else if (shift_data_i) begin
      data_o <= {data_o[DATA_W-2:0], sda_i};
    end else if (shift_ack_i) begin
      ack_flag_o <= sda_i;
    end else if (wr_en_i) begin
      data_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/i2cs_sda_out.sv
module i2cs_sda_out
  import i2cs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  tx_i,
  input  logic  msb_i,
  input  logic  scl_fall_i,
  input  slot_e slot_i,
  input  logic  cnt_zero_i,
  input  logic  ack_drive_i,
  output logic  sda_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_o <= 1'b1;
    end else if (load_i) begin
      sda_o <= tx_i ? msb_i : 1'b1;
    end else if (scl_fall_i) begin
      unique case (slot_i)
        SLOT_DATA: if (!cnt_zero_i) sda_o <= tx_i ? msb_i : 1'b1;
        SLOT_ACK:  sda_o <= tx_i ? 1'b1 : ack_drive_i;
        default:   sda_o <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/i2cs_byte_shifter.sv
module i2cs_byte_shifter
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             start_i,
  input  logic             tx_mode_i,
  input  logic             ack_drive_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_i,
  output logic             sda_o,
  output logic             busy_o,
  output logic             byte_done_o,
  output logic             ack_done_o,
  output logic             ack_bit_o
);
  slot_e             slot;
  logic              cnt_zero;
  logic              shift_data;
  logic              shift_ack;
  logic              start_ok;
  logic              wr_ok;
  logic [DATA_W-1:0] data;
  logic              unused_wdata;

  assign start_ok     = start_i && !busy_o;
  assign wr_ok        = reg_we_i && !busy_o && !start_i;
  assign unused_wdata = ^reg_wdata_i[REG_W-1:DATA_W];
  assign reg_rdata_o  = {{(REG_W-DATA_W){1'b0}}, data};

  i2cs_bit_ctr #(.DATA_W(DATA_W)) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_ok),
    .scl_rise_i   (scl_rise_i),
    .busy_o       (busy_o),
    .slot_o       (slot),
    .cnt_zero_o   (cnt_zero),
    .shift_data_o (shift_data),
    .shift_ack_o  (shift_ack),
    .byte_done_o  (byte_done_o),
    .ack_done_o   (ack_done_o)
  );

  i2cs_shift_chain #(.DATA_W(DATA_W)) u_chain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_ok),
    .wr_data_i    (reg_wdata_i[DATA_W-1:0]),
    .shift_data_i (shift_data),
    .shift_ack_i  (shift_ack),
    .sda_i        (sda_i),
    .data_o       (data),
    .ack_flag_o   (ack_bit_o)
  );

  i2cs_sda_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_ok),
    .tx_i        (tx_mode_i),
    .msb_i       (data[DATA_W-1]),
    .scl_fall_i  (scl_fall_i),
    .slot_i      (slot),
    .cnt_zero_i  (cnt_zero),
    .ack_drive_i (ack_drive_i),
    .sda_o       (sda_o)
  );
endmodule

// File: rtl/i2cs_byte_shifter_chk.sv
module i2cs_byte_shifter_chk
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic             start_i,
  input logic             scl_rise_i,
  input logic             scl_fall_i,
  input logic             sda_i,
  input logic             sda_o,
  input logic             busy_o,
  input logic             byte_done_o,
  input logic             ack_done_o,
  input logic [REG_W-1:0] reg_rdata_o,
  input slot_e            slot_i
);
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:DATA_W] == '0); // R2
  AST_DATA_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == SLOT_DATA && scl_rise_i) |=>
      reg_rdata_o[DATA_W-1:0] == {$past(reg_rdata_o[DATA_W-2:0]), $past(sda_i)}); // R3
  AST_BUSY_WRITE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_we_i && !scl_rise_i) |=> $stable(reg_rdata_o)); // R10
  AST_ACK_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_done_o |-> !busy_o); // R9
  AST_BYTE_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> !byte_done_o); // R11
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_done_o && ack_done_o)); // R11
  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && scl_fall_i) |=> sda_o); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && !reg_we_i) |=> $stable(reg_rdata_o)); // R12
endmodule

bind i2cs_byte_shifter i2cs_byte_shifter_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .start_i     (start_i),
  .scl_rise_i  (scl_rise_i),
  .scl_fall_i  (scl_fall_i),
  .sda_i       (sda_i),
  .sda_o       (sda_o),
  .busy_o      (busy_o),
  .byte_done_o (byte_done_o),
  .ack_done_o  (ack_done_o),
  .reg_rdata_o (reg_rdata_o),
  .slot_i      (slot)
);

// File: tb/tb_i2cs_byte_shifter.sv
`timescale 1ns/1ps
module tb_i2cs_byte_shifter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        start_i = 1'b0;
  logic        tx_mode_i = 1'b0;
  logic        ack_drive_i = 1'b1;
  logic        scl_rise_i = 1'b0;
  logic        scl_fall_i = 1'b0;
  logic        sda_i = 1'b1;
  logic        sda_o, busy_o, byte_done_o, ack_done_o, ack_bit_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  i2cs_byte_shifter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .start_i(start_i), .tx_mode_i(tx_mode_i),
    .ack_drive_i(ack_drive_i), .scl_rise_i(scl_rise_i), .scl_fall_i(scl_fall_i),
    .sda_i(sda_i), .sda_o(sda_o), .busy_o(busy_o), .byte_done_o(byte_done_o),
    .ack_done_o(ack_done_o), .ack_bit_o(ack_bit_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic rise(input logic b);
    sda_i = b; scl_rise_i = 1'b1; tick(); scl_rise_i = 1'b0;
  endtask

  task automatic fall();
    scl_fall_i = 1'b1; tick(); scl_fall_i = 1'b0;
  endtask

  task automatic wr(input logic [31:0] v);
    reg_wdata_i = v; reg_we_i = 1'b1; tick(); reg_we_i = 1'b0;
  endtask

  // mid: 0 none, 1 write while busy, 2 start while busy (both after three data bits)
  task automatic run_byte(input bit tx, input logic [7:0] txb, input logic [7:0] bus,
                          input logic ack_bus, input logic ack_drv, input int mid);
    bit lost = 1'b0;
    logic [31:0] snap;
    tx_mode_i = tx; ack_drive_i = ack_drv;
    if (tx) wr({24'hFFFFFF, txb});
    start_i = 1'b1; tick(); start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    for (int i = 7; i >= 0; i--) begin
      chk(sda_o == ((tx && !lost) ? txb[i] : 1'b1), tx ? "R5 tx bit on sda" : "R8 rx release",
          sda_o, (tx && !lost) ? txb[i] : 1'b1);
      if (i == 4 && mid == 1) begin
        snap = reg_rdata_o;
        wr(32'h0000_00FF);
        chk(reg_rdata_o == snap, "R10 write while busy ignored", reg_rdata_o, snap);
      end
      if (i == 4 && mid == 2) begin
        start_i = 1'b1; tick(); start_i = 1'b0;
        chk(busy_o == 1'b1, "R9 start while busy keeps busy", busy_o, 1);
      end
      rise(bus[i]);
      chk(byte_done_o == (i == 0), "R11 byte_done timing", byte_done_o, (i == 0));
      if (tx && !lost && bus[i] != txb[i]) begin
        lost = 1'b1; tx_mode_i = 1'b0;
      end
      fall();
      if (i == 0) chk(byte_done_o == 1'b0, "R11 byte_done one cycle", byte_done_o, 0);
    end
    chk(reg_rdata_o == {24'h0, bus}, lost ? "R6 bus byte after lost arbitration" : "R3 byte received",
        reg_rdata_o, {24'h0, bus});
    chk(sda_o == (tx_mode_i ? 1'b1 : ack_drv), "R7 ack slot drive", sda_o, tx_mode_i ? 1'b1 : ack_drv);
    rise(ack_bus);
    chk(ack_done_o == 1'b1, "R11 ack_done after ninth edge", ack_done_o, 1);
    chk(busy_o == 1'b0, "R9 busy clears on ninth edge", busy_o, 0);
    chk(ack_bit_o == ack_bus, "R4 ack flag captured", ack_bit_o, ack_bus);
    chk(reg_rdata_o == {24'h0, bus}, "R4 register unchanged by ack", reg_rdata_o, {24'h0, bus});
    fall();
    chk(ack_done_o == 1'b0, "R11 ack_done one cycle", ack_done_o, 0);
    chk(sda_o == 1'b1, "R12 release after byte", sda_o, 1);
  endtask

  task automatic t_reset();
    chk(reg_rdata_o == 32'h0, "R1 reset data", reg_rdata_o, 0);
    chk(sda_o == 1'b1, "R1 reset sda", sda_o, 1);
    chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    chk({byte_done_o, ack_done_o, ack_bit_o} == 3'b0, "R1 reset pulses", {byte_done_o, ack_done_o, ack_bit_o}, 0);
  endtask

  task automatic t_idle_write();
    wr(32'hDEAD_BE5A);
    chk(reg_rdata_o == 32'h0000_005A, "R2 idle write low byte only", reg_rdata_o, 32'h5A);
  endtask

  task automatic t_idle_strobes();
    wr(32'h0000_0081);
    rise(1'b0);
    chk(reg_rdata_o == 32'h81, "R12 idle rise ignored", reg_rdata_o, 32'h81);
    chk(byte_done_o == 1'b0 && busy_o == 1'b0, "R12 no pulse when idle", {byte_done_o, busy_o}, 0);
    fall();
    chk(sda_o == 1'b1, "R12 idle fall releases", sda_o, 1);
  endtask

  task automatic t_start_write_same_cycle();
    wr(32'h0000_003C);
    tx_mode_i = 1'b0;
    reg_wdata_i = 32'h0000_00C3; reg_we_i = 1'b1; start_i = 1'b1;
    tick();
    reg_we_i = 1'b0; start_i = 1'b0;
    chk(reg_rdata_o == 32'h3C, "R10 write with start ignored", reg_rdata_o, 32'h3C);
    for (int i = 7; i >= 0; i--) begin rise(1'b1); fall(); end
    chk(reg_rdata_o == 32'hFF, "R3 all ones received", reg_rdata_o, 32'hFF);
    rise(1'b0); fall();
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_idle_write();
    run_byte(1'b1, 8'hA5, 8'hA5, 1'b0, 1'b1, 0); // R5 R7 full transmit
    run_byte(1'b0, 8'h00, 8'h3C, 1'b1, 1'b0, 0); // R3 R8 R7 receive with ack driven low
    run_byte(1'b1, 8'hF0, 8'hC3, 1'b1, 1'b1, 0); // R6 arbitration lost at bit 5
    run_byte(1'b0, 8'h00, 8'h96, 1'b0, 1'b1, 1); // R10 write mid-byte
    run_byte(1'b0, 8'h00, 8'h5B, 1'b1, 1'b0, 2); // R9 start mid-byte
    t_idle_strobes();
    t_start_write_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule